// File: doc/BRIEF.md
# Toggle-Style Pulse Width Modulator

This block produces a pulse-width-modulated waveform from a free-running up-counter of `CNT_W` bits (16 by default). Each counting step is taken on a clock-enable pulse. A select input decides whether that pulse comes from an internal tick or from an external event. An output flip-flop inverts when the counter reaches the programmed compare value, and inverts again when the counter wraps from all-ones to zero. The time between the two inversions sets the duty.

The wrap also raises a one-cycle interrupt request. The flip-flop's starting level comes from a control input, so both pulse polarities are available. The output pin always carries the complement of the flip-flop.

Software writes the compare value one byte lane at a time into a holding buffer. The buffer reaches the active compare register only at a wrap, or at any time while the block is stopped. A new duty therefore never cuts a period short.

Top module: `pwm_toggle_gen`

## Requirements
- R1: While `run_i` is 1, the counter advances by one only on cycles where the selected enable is high. Enable 0 on `src_sel_i` selects `int_tick_i`, and 1 selects `ext_tick_i`. On all other cycles the counter holds.
- R2: When an advance that is not a wrap brings the counter to a nonzero active compare value, the flip-flop inverts on that same clock edge. Counting then continues.
- R3: An advance taken while the counter holds 2^CNT_W-1 clears the counter to 0, inverts the flip-flop, and drives `irq_o` high for exactly the following cycle.
- R4: `irq_o` is never high except in the cycle after a wrap. A compare match alone never raises it.
- R5: With an active compare value of 0, exactly one inversion occurs per wrap, and no extra inversion occurs on the step away from zero.
- R6: While `run_i` is 0, the counter is held at 0 and the flip-flop loads `init_lvl_i` at each clock edge.
- R7: `pwm_o` is always the complement of the flip-flop state.
- R8: Reset clears the flip-flop to 0 (`pwm_o` = 1), clears the counter and both compare registers, and holds `irq_o` at 0.
- R9: A write with `duty_we_i` = 1 places `duty_byte_i` into buffer bits [8k+7:8k], where k = `duty_bsel_i`. The last lane keeps only the bits that fit in `CNT_W`. The buffer is copied to the active compare register at a wrap, or on every clock edge while `run_i` is 0. A write made while running has no effect on the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable; 0 holds the counter and loads the start level |
| src_sel_i | input | 1 | Count enable source: 0 internal, 1 external |
| int_tick_i | input | 1 | Internal count enable pulse |
| ext_tick_i | input | 1 | External count enable pulse, already synchronous to clk_i |
| init_lvl_i | input | 1 | Start level of the output flip-flop |
| duty_we_i | input | 1 | Byte write strobe into the holding buffer |
| duty_bsel_i | input | SEL_W | Byte lane index of the write |
| duty_byte_i | input | 8 | Write data byte |
| pwm_o | output | 1 | Complement of the output flip-flop |
| irq_o | output | 1 | One-cycle wrap interrupt request |

## Verification
The assertions assume that `ext_tick_i` and `int_tick_i` are already synchronous to `clk_i` and are sampled as clean levels. They also assume that reset is applied long enough to reach every register before `run_i` first rises. The bench drives every input on the falling clock edge and holds it through the next rising edge, so no enable changes near the sampling point. Compare values are reloaded only while stopped or as buffered writes. This allows the zero-duty and mid-period-write cases to be checked against a cycle-exact model.

// File: rtl/pwm_toggle_pkg.sv
package pwm_toggle_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;
endpackage

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int CNT_W = 16,
  localparam int LANES = (CNT_W + 7) / 8,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] bsel_i,
  input  logic [7:0]       byte_i,
  input  logic             load_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] buf_w;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LO = 8 * k;
    localparam int LW = (CNT_W - LO > 8) ? 8 : CNT_W - LO;
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lane_q <= '0;
      else if (we_i && bsel_i == SEL_W'(k))     lane_q <= byte_i[LW-1:0];
    end
    assign buf_w[LO +: LW] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_o <= '0;
    else if (load_i) act_o <= buf_w;
  end

  // R9: active compare only moves at a wrap or while stopped
  a_r9_act_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> $stable(act_o));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             wrap_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  assign step    = run_i && tick_i;
  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap_o  = step && (cnt_q == CNT_MAX);
  // wrap lands on 0, so a zero compare is never seen as a separate match
  assign match_o = step && (cnt_q != CNT_MAX) && (cnt_nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_nxt;
  end

  a_r1_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
  a_r3_clear_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  a_r5_no_double_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap_o && match_o));
endmodule

// File: rtl/pwm_out_ff.sv
module pwm_out_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic init_lvl_i,
  input  logic wrap_i,
  input  logic match_i,
  output logic ff_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= wrap_i;
      if (!run_i)                ff_o <= init_lvl_i;
      else if (wrap_i || match_i) ff_o <= ~ff_o;
    end
  end

  a_r2_toggle_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && match_i) |=> (ff_o != $past(ff_o)));
  a_r3_toggle_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wrap_i) |=> (ff_o != $past(ff_o)));
  a_r4_irq_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(wrap_i));
  a_r6_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ff_o == $past(init_lvl_i)));
endmodule

// File: rtl/pwm_toggle_gen.sv
module pwm_toggle_gen
  import pwm_toggle_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LANES = (CNT_W + 7) / 8,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             src_sel_i,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  input  logic             init_lvl_i,
  input  logic             duty_we_i,
  input  logic [SEL_W-1:0] duty_bsel_i,
  input  logic [7:0]       duty_byte_i,
  output logic             pwm_o,
  output logic             irq_o
);
  tick_src_e        src;
  logic             tick;
  logic             wrap;
  logic             match;
  logic             ff_q;
  logic [CNT_W-1:0] cmp_act;

  assign src  = tick_src_e'(src_sel_i);
  assign tick = (src == SRC_EXT) ? ext_tick_i : int_tick_i;

  pwm_duty_buf #(.CNT_W(CNT_W)) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (duty_we_i),
    .bsel_i (duty_bsel_i),
    .byte_i (duty_byte_i),
    .load_i (wrap || !run_i),
    .run_i  (run_i),
    .act_o  (cmp_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .tick_i  (tick),
    .cmp_i   (cmp_act),
    .wrap_o  (wrap),
    .match_o (match)
  );

  pwm_out_ff u_ff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .init_lvl_i (init_lvl_i),
    .wrap_i     (wrap),
    .match_i    (match),
    .ff_o       (ff_q),
    .irq_o      (irq_o)
  );

  assign pwm_o = ~ff_q;  // R7

  a_r4_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o || $past(wrap));
endmodule

// File: tb/pwm_toggle_gen_tb_top.sv
module pwm_toggle_gen_tb_top;
  localparam int W     = 12;
  localparam int MAXV  = (1 << W) - 1;
  localparam int PER   = 1 << W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run = 1'b0, src_sel = 1'b0, int_tick = 1'b0, ext_tick = 1'b0, init_lvl = 1'b0;
  logic we = 1'b0;
  logic [0:0] bsel = '0;
  logic [7:0] bdat = '0;
  logic pwm, irq;

  int checks = 0, errors = 0;
  string cur_req = "R8";
  int ext_mode = 0;
  int step_no = 0;
  int irq_cnt = 0, tog_cnt = 0;
  logic prev_pwm = 1'b1;
  bit done = 0;

  // reference model state
  int  m_cnt = 0, m_buf = 0, m_act = 0;
  bit  m_ff = 0, m_irq = 0;

  always #10 clk = ~clk;

  pwm_toggle_gen #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .src_sel_i(src_sel),
    .int_tick_i(int_tick), .ext_tick_i(ext_tick), .init_lvl_i(init_lvl),
    .duty_we_i(we), .duty_bsel_i(bsel), .duty_byte_i(bdat),
    .pwm_o(pwm), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_buf = 0; m_act = 0; m_ff = 0; m_irq = 0;
    end else begin
      bit tk;
      bit irq_n;
      int old_buf;
      old_buf = m_buf;
      tk = src_sel ? ext_tick : int_tick;
      irq_n = 0;
      if (!run) begin
        m_cnt = 0; m_ff = init_lvl; m_act = old_buf;
      end else if (tk) begin
        if (m_cnt == MAXV) begin
          m_cnt = 0; m_ff = !m_ff; irq_n = 1; m_act = old_buf;
        end else begin
          m_cnt = m_cnt + 1;
          if (m_cnt == m_act) m_ff = !m_ff;
        end
      end
      if (we) begin
        int sh;
        sh = 8 * int'(bsel);
        m_buf = ((m_buf & ~(8'hFF << sh)) | (int'(bdat) << sh)) & MAXV;
      end
      m_irq = irq_n;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    step_no++;
    chk(cur_req, "pwm_o", int'(pwm), int'(!m_ff));
    chk("R4", "irq_o", int'(irq), int'(m_irq));
    if (irq) irq_cnt++;
    if (pwm != prev_pwm) tog_cnt++;
    prev_pwm = pwm;
    int_tick = 1'b1;
    ext_tick = (ext_mode != 0) ? (step_no % 3 == 0) : 1'b0;
  endtask

  task automatic run_for(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_duty(input int v);
    we = 1'b1; bsel = 1'b0; bdat = v[7:0];
    step();
    bsel = 1'b1; bdat = v[15:8];
    step();
    we = 1'b0;
  endtask

  task automatic clr_cnt();
    irq_cnt = 0; tog_cnt = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "pwm_o in reset", int'(pwm), 1);
    chk("R8", "irq_o in reset", int'(irq), 0);
    rst_ni = 1'b1;
    prev_pwm = pwm;

    // R6: stopped, start level follows init_lvl_i
    cur_req = "R6";
    init_lvl = 1'b0; run_for(3);
    chk("R6", "pwm_o stopped init0", int'(pwm), 1);
    init_lvl = 1'b1; run_for(3);
    chk("R6", "pwm_o stopped init1", int'(pwm), 0);
    init_lvl = 1'b0; run_for(2);

    // R2/R3/R9: duty 0x300 via both lanes, two periods
    cur_req = "R9";
    wr_duty(12'h300);
    run_for(2);
    cur_req = "R2";
    clr_cnt();
    run = 1'b1;
    run_for(2 * PER);
    chk("R3", "irq count over two periods", irq_cnt, 2);
    chk("R2", "toggles over two periods", tog_cnt, 4);

    // R9: write while running, takes effect from the next period
    cur_req = "R9";
    run_for(100);
    wr_duty(12'h0A5);
    run_for(2 * PER);

    // R5: zero duty while stopped
    cur_req = "R5";
    run = 1'b0;
    wr_duty(0);
    run_for(3);
    clr_cnt();
    run = 1'b1;
    run_for(2 * PER);
    chk("R5", "irq count zero duty", irq_cnt, 2);
    chk("R5", "toggles equal wraps at zero duty", tog_cnt, 2);

    // R1: external enable every third cycle, internal always high
    cur_req = "R1";
    run = 1'b0;
    wr_duty(12'h7FF);
    src_sel = 1'b1; ext_mode = 1;
    run_for(3);
    clr_cnt();
    run = 1'b1;
    run_for(3 * PER + 3);
    chk("R1", "irq count on external enable", irq_cnt, 1);
    chk("R1", "toggles on external enable", tog_cnt, 2);

    // R7: negative polarity, stop mid-period
    cur_req = "R7";
    run = 1'b0; src_sel = 1'b0; ext_mode = 0; init_lvl = 1'b1;
    run_for(3);
    chk("R7", "pwm_o init1 stopped", int'(pwm), 0);
    run = 1'b1;
    run_for(PER + 50);
    cur_req = "R6";
    run = 1'b0; init_lvl = 1'b0;
    step();
    run_for(2);
    chk("R6", "pwm_o after stop", int'(pwm), 1);
    chk("R4", "irq_o after stop", int'(irq), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule